// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of up to 32. Every bank has its own set of 32-bit registers, reached through a simple single-cycle read/write port. Software chooses whether each pin is an input or an output, and can always read back the synchronised pin level. It changes output levels only through separate write-one-to-set and write-one-to-clear strobes, so a pin's level is never written directly.

Every pin can be armed to watch for rising edges, falling edges or both. A detected edge is held in a sticky per-bank status register until software writes a one to that bit. A per-bank mask chooses which held edges may raise the single interrupt output. That output is registered and is the OR of the masked status across all banks. The last bank may be partial. Its missing pins read as zero and ignore writes.

Top module: `gpiox_ctrl`

## Requirements
- R1: A register address is the register-type offset plus a bank offset. The type offsets are: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48 and interrupt mask 0x9C. The bank offset is n*4 for banks 0 to 2 and 0x100+(n-3)*4 for bank 3 and above.
- R2: After synchronous reset, every direction, output latch, edge enable, status and mask bit is 0 and `irq` is 0. Reads of set, clear, unaligned or unmapped offsets, or of banks that do not exist, return 0.
- R3: Writing 1s to a bank's set register drives those output latches high. Writing 1s to its clear register drives them low. Zero bits leave a latch unchanged, and `pin_out` shows the latches.
- R4: A direction bit of 1 makes the pin an output (`pin_oe` high). A direction bit of 0 makes it an input. The direction register reads back as written.
- R5: The level register returns the pin input after a two-flop synchroniser, whatever the pin's direction.
- R6: With the rising enable set, a 0-to-1 transition of the synchronised input sets the pin's status bit. With the falling enable set, a 1-to-0 transition sets it. With both set, either transition sets it. With neither set, no status bit is set.
- R7: Status bits stay set until software writes a 1 to that bit position. If an edge arrives in the same cycle as such a clear, the bit stays set.
- R8: `irq` is the registered OR over all banks of (status AND mask). It rises one cycle after a masked bit becomes pending and falls one cycle after the last masked pending bit goes away.
- R9: In a partial last bank, the bits above the last real pin read as 0 in every register and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| pin_in | input | NUM_PINS | Pin levels from the pads |
| pin_out | output | NUM_PINS | Output latches |
| pin_oe | output | NUM_PINS | Output enables (direction bits) |
| irq | output | 1 | Combined edge interrupt |

## Verification
A table of register writes and read-backs covers banks in both address windows, a partial bank, write-only offsets and unmapped offsets. This tells decode errors apart from storage errors. The edge tests arm rising-only, falling-only and both-edge pins in one bank. Each test then drives a rise and a fall, so a swapped or missing polarity shows as a wrong status pattern. The interrupt tests toggle the mask against pending status and check `irq` on the exact cycle it should change. A clear is also timed to land in the cycle an edge is captured, which separates "edge wins" from "clear wins".

// File: rtl/gpiox_pkg.sv
package gpiox_pkg;

    localparam int BANK_BITS = 32;
    localparam int WIN_BANKS = 3;
    localparam int ADDR_W    = 10;

    typedef enum logic [3:0] {
        RK_LEVEL, RK_DIR, RK_SET, RK_CLR, RK_RISE, RK_FALL, RK_STAT, RK_MASK, RK_NONE
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [7:0] bank;
    } decode_t;

    typedef struct packed {
        logic [BANK_BITS-1:0] level;
        logic [BANK_BITS-1:0] dir;
        logic [BANK_BITS-1:0] rise;
        logic [BANK_BITS-1:0] fall;
        logic [BANK_BITS-1:0] stat;
        logic [BANK_BITS-1:0] mask;
    } bank_view_t;

    // Register types sit 12 bytes apart; inside each 12-byte slot the bank
    // index within the window is the word number.
    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a, input int nbanks);
        decode_t d;
        int o, slot, sub, bk;
        o    = int'(a[7:0]);
        slot = o / 12;
        sub  = (o % 12) / 4;
        bk   = (a[8] ? WIN_BANKS : 0) + sub;
        case (slot)
            0:       d.kind = RK_LEVEL;
            1:       d.kind = RK_DIR;
            2:       d.kind = RK_SET;
            3:       d.kind = RK_CLR;
            4:       d.kind = RK_RISE;
            5:       d.kind = RK_FALL;
            6:       d.kind = RK_STAT;
            13:      d.kind = RK_MASK;
            default: d.kind = RK_NONE;
        endcase
        d.bank = 8'(bk);
        d.hit  = (a[1:0] == 2'b00) && !a[9] && (bk < nbanks) && (d.kind != RK_NONE);
        return d;
    endfunction

endpackage

// File: rtl/gpiox_sync.sv
module gpiox_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpiox_bank.sv
module gpiox_bank
    import gpiox_pkg::*;
#(
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  reg_kind_e     wr_kind,
    input  logic [LW-1:0] wdata,
    input  logic [LW-1:0] pin_in,
    output logic [LW-1:0] pin_out,
    output logic [LW-1:0] pin_oe,
    output bank_view_t    view,
    output logic          pend
);
    logic [LW-1:0] lvl, prev_q, dir_q, out_q, rise_q, fall_q, stat_q, mask_q;
    logic [LW-1:0] hits, clr_bits;

    gpiox_sync #(.W(LW)) u_sync (.clk(clk), .rst(rst), .d(pin_in), .q(lvl));

    assign hits     = (lvl & ~prev_q & rise_q) | (~lvl & prev_q & fall_q);
    assign clr_bits = (wr_en && wr_kind == RK_STAT) ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= (stat_q & ~clr_bits) | hits;
            if (wr_en) begin
                case (wr_kind)
                    RK_DIR:  dir_q  <= wdata;
                    RK_SET:  out_q  <= out_q | wdata;
                    RK_CLR:  out_q  <= out_q & ~wdata;
                    RK_RISE: rise_q <= wdata;
                    RK_FALL: fall_q <= wdata;
                    RK_MASK: mask_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
    assign pend    = |(stat_q & mask_q);

    always_comb begin
        view.level = BANK_BITS'(lvl);
        view.dir   = BANK_BITS'(dir_q);
        view.rise  = BANK_BITS'(rise_q);
        view.fall  = BANK_BITS'(fall_q);
        view.stat  = BANK_BITS'(stat_q);
        view.mask  = BANK_BITS'(mask_q);
    end

    // R3: output latches move only on a set or clear strobe
    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_kind == RK_SET || wr_kind == RK_CLR)) |=> $stable(out_q));

    // R7: without a status write no pending bit is dropped
    assert_stat_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_kind == RK_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R6 / R7: every detected edge is held, even against a clear
    assert_edge_latched_R6: assert property (@(posedge clk) disable iff (rst)
        (|hits) |=> ((stat_q & $past(hits)) == $past(hits)));
endmodule

// File: rtl/gpiox_ctrl.sv
module gpiox_ctrl
    import gpiox_pkg::*;
#(
    parameter int NUM_PINS = 100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NBANKS = (NUM_PINS + BANK_BITS - 1) / BANK_BITS;

    decode_t    dec;
    bank_view_t views [NBANKS];
    bank_view_t sel;
    logic [NBANKS-1:0] pend_v;

    assign dec = decode_addr(bus_addr, NBANKS);

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        localparam int LW = (NUM_PINS - BANK_BITS*b > BANK_BITS) ? BANK_BITS
                                                                 : NUM_PINS - BANK_BITS*b;
        logic wr_here;
        assign wr_here = bus_en && bus_wr && dec.hit && (dec.bank == 8'(b));

        gpiox_bank #(.LW(LW)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (wr_here),
            .wr_kind(dec.kind),
            .wdata  (bus_wdata[LW-1:0]),
            .pin_in (pin_in[BANK_BITS*b +: LW]),
            .pin_out(pin_out[BANK_BITS*b +: LW]),
            .pin_oe (pin_oe[BANK_BITS*b +: LW]),
            .view   (views[b]),
            .pend   (pend_v[b])
        );
    end

    always_comb begin
        sel = '0;
        for (int b = 0; b < NBANKS; b++)
            if (dec.bank == 8'(b)) sel = views[b];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_wr && dec.hit) begin
            case (dec.kind)
                RK_LEVEL: bus_rdata = sel.level;
                RK_DIR:   bus_rdata = sel.dir;
                RK_RISE:  bus_rdata = sel.rise;
                RK_FALL:  bus_rdata = sel.fall;
                RK_STAT:  bus_rdata = sel.stat;
                RK_MASK:  bus_rdata = sel.mask;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |pend_v;
    end

    // R8: interrupt tracks masked pending status one cycle later
    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
        (|pend_v) |=> irq);
    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (rst)
        !(|pend_v) |=> !irq);
endmodule

// File: tb/tb_gpiox_ctrl.sv
module tb_gpiox_ctrl;
    localparam int NP = 100;

    logic clk = 0, rst = 1;
    logic bus_en = 0, bus_wr = 0;
    logic [9:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
    logic irq;
    int n_chk = 0, n_err = 0;

    gpiox_ctrl #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #2 clk = ~clk;

    localparam logic [9:0] O_LVL = 10'h000, O_DIR = 10'h00C, O_SET = 10'h018,
                           O_CLR = 10'h024, O_RIS = 10'h030, O_FAL = 10'h03C,
                           O_STA = 10'h048, O_MSK = 10'h09C;

    function automatic logic [9:0] ra(input logic [9:0] off, input int bank);
        return off + ((bank < 3) ? 10'(bank*4) : 10'(256 + (bank-3)*4));
    endfunction

    typedef struct packed {
        logic [9:0]  addr;
        logic [31:0] wdata;
        logic [31:0] expv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{10'h00C, 32'hA5A5_0F0F, 32'hA5A5_0F0F},  // R4 dir bank0
        '{10'h10C, 32'hFFFF_FFFF, 32'h0000_000F},  // R9 dir partial bank3
        '{10'h014, 32'h1234_5678, 32'h1234_5678},  // R1 dir bank2
        '{10'h034, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R1 rise bank1
        '{10'h040, 32'h0000_FFFF, 32'h0000_FFFF},  // R1 fall bank1
        '{10'h0A0, 32'h8000_0001, 32'h8000_0001},  // R1 mask bank1
        '{10'h018, 32'h0000_FFFF, 32'h0000_0000},  // R2 set is write-only
        '{10'h054, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 unmapped slot
        '{10'h110, 32'hFFFF_FFFF, 32'h0000_0000}   // R2 bank4 absent
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk); rst = 0;
        @(negedge clk);
    endtask

    initial begin
        #(4*100000);
        n_err++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R2 reset state
        rd(ra(O_DIR, 0), v); chk("R2 dir reset", v, 0);
        rd(ra(O_MSK, 3), v); chk("R2 mask reset", v, 0);
        rd(ra(O_RIS, 2), v); chk("R2 rise reset", v, 0);
        chk("R2 oe reset", pin_oe[31:0], 0);
        chk("R2 out reset", pin_out[31:0], 0);
        chk("R2 irq reset", 32'(irq), 0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].addr, VEC[i].wdata);
            rd(VEC[i].addr, v);
            chk($sformatf("R1/R2/R4/R9 vector %0d", i), v, VEC[i].expv);
        end
        chk("R4 pin_oe bank0", pin_oe[31:0], 32'hA5A5_0F0F);
        chk("R9 pin_oe bank3", 32'(pin_oe[99:96]), 32'hF);

        do_reset();
        // R3 set/clear strobes
        wr(ra(O_SET, 0), 32'h0000_00FF); chk("R3 set", pin_out[31:0], 32'hFF);
        wr(ra(O_CLR, 0), 32'h0000_000F); chk("R3 clear", pin_out[31:0], 32'hF0);
        wr(ra(O_SET, 0), 32'h0);         chk("R3 zero set", pin_out[31:0], 32'hF0);
        wr(ra(O_SET, 3), 32'hFFFF_FFFF); chk("R3 set bank3", 32'(pin_out[99:96]), 32'hF);

        // R5 level readback regardless of direction
        wr(ra(O_DIR, 0), 32'hFFFF_0000);
        pin_in[31:0] = 32'h1234_ABCD;
        settle();
        rd(ra(O_LVL, 0), v); chk("R5 level bank0", v, 32'h1234_ABCD);
        pin_in[31:0] = 32'h0;
        settle();
        rd(ra(O_LVL, 0), v); chk("R5 level low", v, 32'h0);

        // R6 polarity: bit0 rise, bit1 fall, bit2 both
        wr(ra(O_RIS, 0), 32'h5);
        wr(ra(O_FAL, 0), 32'h6);
        pin_in[2:0] = 3'b111; settle();
        rd(ra(O_STA, 0), v); chk("R6 rising", v, 32'h5);
        wr(ra(O_STA, 0), 32'h7);
        rd(ra(O_STA, 0), v); chk("R7 w1c clears", v, 32'h0);
        pin_in[2:0] = 3'b000; settle();
        rd(ra(O_STA, 0), v); chk("R6 falling", v, 32'h6);
        pin_in[5:3] = 3'b111; settle();
        rd(ra(O_STA, 0), v); chk("R6 unarmed pins", v, 32'h6);

        // R8 mask gating and irq timing
        chk("R8 irq masked off", 32'(irq), 0);
        wr(ra(O_MSK, 0), 32'h2);
        chk("R8 irq not yet", 32'(irq), 0);
        @(negedge clk);
        chk("R8 irq raised", 32'(irq), 1);
        wr(ra(O_STA, 0), 32'h2);
        chk("R8 irq one cycle late", 32'(irq), 1);
        @(negedge clk);
        chk("R8 irq dropped", 32'(irq), 0);
        rd(ra(O_STA, 0), v); chk("R7 partial clear", v, 32'h4);
        wr(ra(O_STA, 0), 32'hFFFF_FFFF);

        // R7 edge arriving with a clear wins
        pin_in[0] = 1'b1; settle();
        rd(ra(O_STA, 0), v); chk("R7 setup", v, 32'h1);
        pin_in[0] = 1'b0; settle();
        @(negedge clk); pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(ra(O_STA, 0), 32'h1);
        rd(ra(O_STA, 0), v); chk("R7 edge beats clear", v, 32'h1);

        // R9 / R1 second window, partial bank
        wr(ra(O_RIS, 3), 32'hFFFF_FFFF);
        wr(ra(O_MSK, 3), 32'h8);
        pin_in[99] = 1'b1; settle();
        rd(ra(O_STA, 3), v); chk("R9 bank3 status", v, 32'h8);
        chk("R8 irq from bank3", 32'(irq), 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule